// File: doc/BRIEF.md
# RC Charge-Time Entropy Seed Sampler

The block builds a hard-to-predict seed by timing how long an external RC network on one pin takes to charge. A sample starts by driving the pin low to empty the capacitor. The block then releases the pin and runs a timer until a synchronized rising edge shows up on the pin. The low bits of the timer at that edge make up the sample.

Each discharge after the first lasts a number of cycles picked by the two lowest bits of the previous sample. The capacitor therefore starts the next charge from a level that depends on the last measurement. Successive samples are XOR-folded into a seed register. A one-cycle done pulse marks the end of the programmed number of samples. A charge that never reaches the high threshold within the timeout ends the run with an error flag.

Top module: `rc_seed_sampler`

## Requirements
- R1: After reset the pin is released (`pin_oe_o`=0), `done_o`=0, `err_o`=0 and `seed_o`=0.
- R2: A `start_i` pulse while idle clears the seed and the error flag and latches `n_samples_i`. The first discharge then holds `pin_oe_o`=1 with `pin_drv_o`=0 for exactly 16 cycles.
- R3: On release the timer restarts from zero and counts once per cycle. The sample is the low 16 bits of the timer, taken on the cycle when the two-flop-synchronized pin first rises. A pin that reads high D cycles after release therefore gives the sample D+2.
- R4: Every later discharge lasts 16 << s cycles, where s is bits [1:0] of the previous sample. So s = 0, 1, 2, 3 gives 16, 32, 64 and 128 cycles.
- R5: At the end of a run `seed_o` equals the XOR of all samples of that run. `done_o` is high for exactly one cycle, on the same edge that the final seed appears.
- R6: A run collects exactly the latched sample count. A count of 0 behaves as 1.
- R7: `start_i` has no effect while a run is in progress.
- R8: If no rise is seen within TIMEOUT_CYC timer cycles, `err_o` is set and the block goes idle with no done pulse. A rise on the last allowed cycle (sample value TIMEOUT_CYC-1) still counts as a sample. `err_o` stays set until the next start.
- R9: While idle with no start, `seed_o` and `err_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted only while idle) |
| n_samples_i | input | SAMP_W | Number of samples per run; 0 means 1 |
| pin_i | input | 1 | Raw level of the RC pin |
| pin_oe_o | output | 1 | Tristate enable for the pin driver |
| pin_drv_o | output | 1 | Value driven on the pin when enabled (always 0) |
| seed_o | output | SEED_W | XOR-folded seed |
| done_o | output | 1 | One-cycle pulse when the run completes |
| err_o | output | 1 | Charge timeout flag |

## Verification
A pin that the RC model raises D cycles after release is seen by the control logic two edges later. The sample, the seed update and the done pulse all land on the edge after that, so the sample equals D+2. The bench samples `done_o` on falling edges and compares the seed against XORs of D+2 that it computes itself. The discharge length is taken from the number of rising edges at which `pin_oe_o` reads high, and this count must equal 16 << s exactly. Along the timeout boundary, D = TIMEOUT_CYC-3 must still produce a sample and D = TIMEOUT_CYC-2 must raise the error flag.

// File: rtl/rc_seed_pkg.sv
package rc_seed_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DISCH  = 2'd1,
    ST_CHARGE = 2'd2
  } rc_state_t;
endpackage

// File: rtl/rc_pin_sync.sv
module rc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] ff_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= ff_q[STAGES-1];

  assign rise_o = ff_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rc_dis_len.sv
module rc_dis_len #(
  parameter int DIS_BASE = 16,
  parameter int SEL_W    = 2,
  parameter int LEN_W    = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [LEN_W-1:0] len_o
);
  assign len_o = LEN_W'(DIS_BASE) << sel_i;
endmodule

// File: rtl/rc_seed_sampler.sv
module rc_seed_sampler
  import rc_seed_pkg::*;
#(
  parameter int SEED_W      = 16,
  parameter int SAMP_W      = 4,
  parameter int SEL_W       = 2,
  parameter int DIS_BASE    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 1 << 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SAMP_W-1:0] n_samples_i,
  input  logic              pin_i,
  output logic              pin_oe_o,
  output logic              pin_drv_o,
  output logic [SEED_W-1:0] seed_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC);
  localparam int TMR_W = (CNT_W > SEED_W) ? CNT_W : SEED_W;

  rc_state_t         st_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [SEED_W-1:0] seed_q;
  logic [SAMP_W-1:0] cnt_q, n_q;
  logic              done_q, err_q;
  logic              rise;
  logic [TMR_W-1:0]  dis_len;
  logic [SEED_W-1:0] cap;
  logic              last_smp;

  rc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise)
  );

  rc_dis_len #(.DIS_BASE(DIS_BASE), .SEL_W(SEL_W), .LEN_W(TMR_W)) u_len (
    .sel_i(sel_q),
    .len_o(dis_len)
  );

  assign cap      = tmr_q[SEED_W-1:0];
  // count 0 treated as 1
  assign last_smp = ({1'b0, cnt_q} + 1'b1) >= {1'b0, n_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      sel_q  <= '0;
      seed_q <= '0;
      cnt_q  <= '0;
      n_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_DISCH;
          tmr_q  <= '0;
          sel_q  <= '0;
          seed_q <= '0;
          cnt_q  <= '0;
          n_q    <= n_samples_i;
          err_q  <= 1'b0;
        end
        ST_DISCH: begin
          if (tmr_q == dis_len - 1'b1) begin
            st_q  <= ST_CHARGE;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_CHARGE: begin
          if (rise) begin
            seed_q <= seed_q ^ cap;
            sel_q  <= cap[SEL_W-1:0];
            tmr_q  <= '0;
            cnt_q  <= cnt_q + 1'b1;
            if (last_smp) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= ST_DISCH;
            end
          end else if (tmr_q == TMR_W'(TIMEOUT_CYC - 1)) begin
            err_q <= 1'b1;
            tmr_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pin_oe_o  = (st_q == ST_DISCH);
  assign pin_drv_o = 1'b0;
  assign seed_o    = seed_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/rc_seed_sampler_chk.sv
module rc_seed_sampler_chk
  import rc_seed_pkg::*;
#(
  parameter int SEED_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic              err_o,
  input logic [SEED_W-1:0] seed_o,
  input rc_state_t         st_q
);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_from_charge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(st_q) == ST_CHARGE);

  assert_no_done_with_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !err_o);

  assert_err_from_charge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(st_q) == ST_CHARGE);

  assert_seed_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> $stable(seed_o));

  assert_err_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> $stable(err_o));
endmodule

bind rc_seed_sampler rc_seed_sampler_chk #(.SEED_W(SEED_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .done_o (done_o),
  .err_o  (err_o),
  .seed_o (seed_o),
  .st_q   (st_q)
);

// File: tb/tb_rc_seed_sampler.sv
module tb_rc_seed_sampler;
  localparam int TO     = 200;
  localparam int SEED_W = 16;
  localparam int SAMP_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, pin_i = 1'b0;
  logic [SAMP_W-1:0] n_samples_i = '0;
  logic pin_oe_o, pin_drv_o, done_o, err_o;
  logic [SEED_W-1:0] seed_o;

  int checks = 0, errors = 0;
  int dly [64];
  int meas_len [64];
  int rel_n = 0, rc_cnt = 0, hi_cnt = 0, cur_d = 1, dn, drv_bad = 0;
  logic oe_d = 1'b0;

  always #10 clk_i = ~clk_i;

  rc_seed_sampler #(.SEED_W(SEED_W), .SAMP_W(SAMP_W), .TIMEOUT_CYC(TO)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .n_samples_i(n_samples_i),
    .pin_i(pin_i), .pin_oe_o(pin_oe_o), .pin_drv_o(pin_drv_o),
    .seed_o(seed_o), .done_o(done_o), .err_o(err_o));

  // behavioural RC: pin reads high dly cycles after release
  always @(posedge clk_i) begin
    oe_d <= pin_oe_o;
    if (pin_oe_o) begin
      rc_cnt <= 0;
      pin_i  <= 1'b0;
      hi_cnt <= hi_cnt + 1;
      if (pin_drv_o !== 1'b0) drv_bad <= drv_bad + 1;
    end else begin
      if (oe_d) begin
        meas_len[rel_n % 64] <= hi_cnt;
        dn = dly[rel_n % 64];
        cur_d <= dn;
        rel_n <= rel_n + 1;
      end else begin
        dn = cur_d;
      end
      rc_cnt <= rc_cnt + 1;
      pin_i  <= (rc_cnt + 1 >= dn);
      hi_cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk_i);
    n_samples_i = SAMP_W'(n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // one run; d_list entries already written at dly[base..]
  task automatic run_ok(input int n_in, input int n_eff, input bit poke);
    int base, pulses, got;
    logic [SEED_W-1:0] exp_seed;
    int sel, c, len;
    base = rel_n;
    pulse_start(n_in);
    chk(err_o == 1'b0, "R2 err cleared", int'(err_o), 0);
    pulses = 0; got = 0;
    for (int cyc = 0; cyc < 20000 && !got; cyc++) begin
      @(negedge clk_i);
      if (poke && cyc == 7) start_i = 1'b1;
      if (poke && cyc == 8) start_i = 1'b0;
      if (done_o) begin pulses++; got = 1; end
    end
    chk(got == 1, "R5 done seen", got, 1);
    exp_seed = '0; sel = 0;
    for (int k = 0; k < n_eff; k++) begin
      len = 16 << sel;
      chk(meas_len[(base + k) % 64] == len, (k == 0) ? "R2 first discharge" : "R4 discharge len",
          meas_len[(base + k) % 64], len);
      c = dly[(base + k) % 64] + 2;
      exp_seed ^= SEED_W'(c);
      sel = c & 3;
    end
    chk(seed_o == exp_seed, "R3 R5 seed", int'(seed_o), int'(exp_seed));
    chk(rel_n - base == n_eff, poke ? "R7 no restart" : "R6 sample count", rel_n - base, n_eff);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5 done one cycle", int'(done_o), 0);
    repeat (20) @(negedge clk_i);
    chk(seed_o == exp_seed && err_o == 1'b0, "R9 hold", int'(seed_o), int'(exp_seed));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) dly[i] = 5;
    repeat (3) @(negedge clk_i);
    chk(pin_oe_o == 0 && done_o == 0 && err_o == 0 && seed_o == 0, "R1 reset state",
        int'({pin_oe_o, done_o, err_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R3 single-sample sweep
    for (int d = 1; d <= 24; d++) begin
      dly[rel_n % 64] = d;
      run_ok(1, 1, 0);
    end

    // R4 every selector value
    dly[(rel_n + 0) % 64] = 3;
    dly[(rel_n + 1) % 64] = 4;
    dly[(rel_n + 2) % 64] = 5;
    dly[(rel_n + 3) % 64] = 6;
    dly[(rel_n + 4) % 64] = 9;
    run_ok(5, 5, 0);

    // R6 zero count behaves as one
    dly[rel_n % 64] = 11;
    run_ok(0, 1, 0);

    // R6 full count, varied delays
    for (int k = 0; k < 15; k++) dly[(rel_n + k) % 64] = 1 + (k * 13) % 37;
    run_ok(15, 15, 0);

    // R7 start during run
    for (int k = 0; k < 3; k++) dly[(rel_n + k) % 64] = 20 + k;
    run_ok(3, 3, 1);

    // R8 last allowed cycle still samples
    dly[rel_n % 64] = TO - 3;
    run_ok(1, 1, 0);

    // R8 timeout boundary
    begin
      int base, pulses;
      dly[rel_n % 64] = TO - 2;
      dly[(rel_n + 1) % 64] = TO - 2;
      base = rel_n;
      pulse_start(2);
      pulses = 0;
      for (int cyc = 0; cyc < 600; cyc++) begin
        @(negedge clk_i);
        if (done_o) pulses++;
      end
      chk(err_o == 1'b1, "R8 timeout err", int'(err_o), 1);
      chk(pulses == 0, "R8 no done", pulses, 0);
      chk(rel_n - base == 1, "R8 stopped", rel_n - base, 1);
      chk(pin_oe_o == 1'b0, "R8 idle", int'(pin_oe_o), 0);
    end

    // recovery after error
    dly[rel_n % 64] = 7;
    dly[(rel_n + 1) % 64] = 8;
    run_ok(2, 2, 0);

    chk(drv_bad == 0, "R2 drive low", drv_bad, 0);
    finish_up();
  end
endmodule